// File: doc/BRIEF.md
# Four-Lane Float Bounds Comparator

The unit takes two 128-bit operand vectors, each packed with four IEEE-754 single-precision values, and tests every lane for containment: does the A value lie inside the closed interval whose edges are minus B and plus B? Each lane does not produce a yes/no mask. Instead it returns a pair of violation flags in the two most significant bits of its 32-bit result word. One flag marks a value above the upper edge. The other marks a value below the lower edge.

A single summary bit records that no lane raised either flag. When the record flag accompanies an operation, this bit is written into a 4-bit condition field together with a write enable. All results appear one clock after the operation's valid strobe. Ordering is done entirely in logic: signed zeros are equal, infinities sort normally, subnormals are compared without flushing, and a NaN in either operand counts as a violation of both edges.

Top module: `fbc_bounds_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. A synchronous active-high reset clears `out_valid`, `result`, `cond` and `cond_we` to zero.
- R2: Lane i occupies bits [32i+31:32i] of each vector. Result bit 32i+31 is set when A is greater than B in that lane under float ordering. Infinities order above and below every finite value, and subnormals are compared by value.
- R3: Result bit 32i+30 is set when A is less than B with its sign bit inverted, i.e. below minus B. If B is negative, the two edges swap, and a lane can then raise both flags.
- R4: If the A or the B value of a lane is a NaN (exponent all ones, mantissa non-zero), both bit 31 and bit 30 of that lane are set.
- R5: Bits 29 down to 0 of every result lane are always zero.
- R6: Positive and negative zero compare equal. Zero A against zero B, of either sign, sets neither flag.
- R7: For a valid operation with `rec_en` high, `cond_we` is 1 in the result cycle. `cond` is {bit3 lt=0, bit2 gt=0, bit1 eq, bit0 so=0}, where eq is 1 only if no lane set either flag.
- R8: For a valid operation with `rec_en` low, `cond_we` is 0 and `cond` is 0 in the result cycle.
- R9: In a cycle after one with `in_valid` low, `out_valid` and `cond_we` are 0, and `result` and `cond` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opnd_a | input | 128 | Four single-precision values tested against the bounds |
| opnd_b | input | 128 | Four single-precision bound magnitudes |
| rec_en | input | 1 | Request a condition field write for this operation |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Per-lane flag pair in bits 31:30 of each word |
| cond | output | 4 | Condition field {lt, gt, eq, so} |
| cond_we | output | 1 | Condition field write enable |

## Verification
The bench aims at ordering edge cases. A design that compared raw bit patterns would order negative values backwards and separate +0 from -0. A design that flushed subnormals would miss flags on tiny values. A design that negated B with arithmetic would misplace the lower edge. NaN in either operand, infinite bounds and negative bounds (where both flags can fire together) each expose a missing special case. The bench also alternates the record flag and inserts idle gaps, which catches a summary bit taken from the wrong lanes, a write enable raised without a request, and results that change when no operation was issued.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    // Condition field layout; bit order is decoded by the consumer.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

endpackage

// File: rtl/fbc_class.sv
// Classifies one float and maps it to a key whose unsigned order
// matches float order for non-NaN values (zeros handled separately).
module fbc_class #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val,
    output logic                 is_nan,
    output logic                 is_zero,
    output logic [EXP_W+MAN_W:0] key
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             sign_f;

    always_comb begin
        sign_f  = val[W-1];
        exp_f   = val[W-2:MAN_W];
        man_f   = val[MAN_W-1:0];
        is_nan  = (&exp_f) && (|man_f);
        is_zero = ~|val[W-2:0];
        if (sign_f) begin
            key = ~val;
        end else begin
            key = {1'b1, val[W-2:0]};
        end
    end
endmodule

// File: rtl/fbc_order.sv
// Strict "x greater than y" for two non-NaN values given their keys.
module fbc_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] key_x,
    input  logic [W-1:0] key_y,
    input  logic         zero_x,
    input  logic         zero_y,
    output logic         x_gt_y
);
    always_comb begin
        x_gt_y = !(zero_x && zero_y) && (key_x > key_y);
    end
endmodule

// File: rtl/fbc_lane.sv
// One lane: high-edge and low-edge violation flags.
module fbc_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] lane_a,
    input  logic [EXP_W+MAN_W:0] lane_b,
    output logic                 above_hi,
    output logic                 below_lo
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [W-1:0] neg_b;
    logic [W-1:0] key_a, key_b, key_nb;
    logic         nan_a, nan_b, nan_nb;
    logic         zero_a, zero_b, zero_nb;
    logic         a_gt_b, nb_gt_a;

    always_comb begin
        neg_b = {~lane_b[W-1], lane_b[W-2:0]};
    end

    fbc_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_a (
        .val(lane_a), .is_nan(nan_a), .is_zero(zero_a), .key(key_a)
    );
    fbc_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_b (
        .val(lane_b), .is_nan(nan_b), .is_zero(zero_b), .key(key_b)
    );
    fbc_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_nb (
        .val(neg_b), .is_nan(nan_nb), .is_zero(zero_nb), .key(key_nb)
    );

    fbc_order #(.W(W)) i_cmp_hi (
        .key_x(key_a), .key_y(key_b), .zero_x(zero_a), .zero_y(zero_b),
        .x_gt_y(a_gt_b)
    );
    fbc_order #(.W(W)) i_cmp_lo (
        .key_x(key_nb), .key_y(key_a), .zero_x(zero_nb), .zero_y(zero_a),
        .x_gt_y(nb_gt_a)
    );

    always_comb begin
        // nan_nb equals nan_b; both kept so each comparator sees its own class
        above_hi = nan_a || nan_b  || a_gt_b;
        below_lo = nan_a || nan_nb || nb_gt_a;
    end
endmodule

// File: rtl/fbc_bounds_unit.sv
module fbc_bounds_unit
    import fbc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [LANES*(EXP_W+MAN_W+1)-1:0]     opnd_a,
    input  logic [LANES*(EXP_W+MAN_W+1)-1:0]     opnd_b,
    input  logic                                 rec_en,
    output logic                                 out_valid,
    output logic [LANES*(EXP_W+MAN_W+1)-1:0]     result,
    output logic [3:0]                           cond,
    output logic                                 cond_we
);
    localparam int LANE_W = EXP_W + MAN_W + 1;
    localparam int VEC_W  = LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
        cond_t            cnd;
        logic             we;
    } state_t;

    state_t           st_d, st_q;
    logic [LANES-1:0] hi_flag, lo_flag;
    logic [VEC_W-1:0] lane_res;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fbc_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_lane (
            .lane_a  (opnd_a[g*LANE_W +: LANE_W]),
            .lane_b  (opnd_b[g*LANE_W +: LANE_W]),
            .above_hi(hi_flag[g]),
            .below_lo(lo_flag[g])
        );
        assign lane_res[g*LANE_W +: LANE_W] = {hi_flag[g], lo_flag[g], {(LANE_W-2){1'b0}}};
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = in_valid && rec_en;
        if (in_valid) begin
            st_d.res = lane_res;
            if (rec_en) begin
                st_d.cnd.lt = 1'b0;
                st_d.cnd.gt = 1'b0;
                st_d.cnd.eq = ~|{hi_flag, lo_flag};
                st_d.cnd.so = 1'b0;
            end else begin
                st_d.cnd = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign cond      = st_q.cnd;
    assign cond_we   = st_q.we;
endmodule

// File: rtl/fbc_bounds_chk.sv
module fbc_bounds_chk #(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              in_valid,
    input logic                              rec_en,
    input logic                              out_valid,
    input logic [LANES*(EXP_W+MAN_W+1)-1:0]  result,
    input logic [3:0]                        cond,
    input logic                              cond_we
);
    localparam int LANE_W = EXP_W + MAN_W + 1;

    logic [LANES-1:0] low_clear;
    for (genvar g = 0; g < LANES; g++) begin : g_low
        assign low_clear[g] = ~|result[g*LANE_W +: LANE_W-2];
    end

    // R1: strobe follows one cycle later
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: idle cycle leaves outputs untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !cond_we && $stable(result) && $stable(cond)));

    // R5: low bits of each lane stay zero
    p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
        &low_clear);

    // R7: record write shape and summary agree with the lane flags
    p_cond_shape_r7: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond[3:2] == 2'b00 && !cond[0] && cond[1] == ~|result));

    // R7: record request yields a write
    p_rec_write_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rec_en) |=> cond_we);

    // R8: no record request, no write, field cleared
    p_rec_off_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rec_en) |=> (!cond_we && cond == 4'b0000));
endmodule

bind fbc_bounds_unit fbc_bounds_chk #(
    .LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W)
) i_fbc_bounds_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rec_en(rec_en),
    .out_valid(out_valid), .result(result), .cond(cond), .cond_we(cond_we)
);

// File: tb/test_fbc_bounds_unit.sv
`timescale 1ns/1ps
module test_fbc_bounds_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] opnd_a, opnd_b;
    logic         rec_en;
    logic         out_valid;
    logic [127:0] result;
    logic [3:0]   cond;
    logic         cond_we;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // expected state
    logic         e_vld = 0;
    logic [127:0] e_res = '0;
    logic [3:0]   e_cond = '0;
    logic         e_we = 0;
    string        e_tag [4];
    logic         e_rec_last = 0;

    always #2.5 clk = ~clk;

    fbc_bounds_unit i_fbc_bounds_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .rec_en(rec_en), .out_valid(out_valid),
        .result(result), .cond(cond), .cond_we(cond_we)
    );

    function automatic real to_real(input logic [31:0] x);
        int e;
        real m;
        e = int'(x[30:23]);
        m = real'(x[22:0]);
        if (e == 255) return x[31] ? -1.0e300 : 1.0e300;
        if (e == 0) m = m * (2.0 ** (-149));
        else        m = (m + 8388608.0) * (2.0 ** (e - 150));
        return x[31] ? -m : m;
    endfunction

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    task automatic cmp(input logic [127:0] act, input logic [127:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        cmp({127'b0, out_valid}, {127'b0, e_vld}, "R1 out_valid");
        for (int i = 0; i < 4; i++) begin
            cmp({126'b0, result[32*i+31 -: 2]}, {126'b0, e_res[32*i+31 -: 2]}, e_tag[i]);
            cmp({98'b0, result[32*i +: 30]}, 128'b0, "R5 low bits");
        end
        cmp({127'b0, cond_we}, {127'b0, e_we}, e_vld ? (e_rec_last ? "R7 cond_we" : "R8 cond_we") : "R9 cond_we");
        cmp({124'b0, cond}, {124'b0, e_cond}, e_vld ? (e_rec_last ? "R7 cond" : "R8 cond") : "R9 cond");
    endtask

    task automatic step(input logic [127:0] a, input logic [127:0] b, input bit v, input bit r);
        logic [1:0] fl;
        bit any;
        @(negedge clk);
        check_outputs();
        in_valid = v; rec_en = r; opnd_a = a; opnd_b = b;
        e_vld = v;
        e_we  = v && r;
        if (!v) begin
            for (int i = 0; i < 4; i++) e_tag[i] = "R9 held result";
        end else begin
            any = 0;
            e_rec_last = r;
            for (int i = 0; i < 4; i++) begin
                logic [31:0] la, lb;
                real ra, rb;
                la = a[32*i +: 32]; lb = b[32*i +: 32];
                if (is_nan(la) || is_nan(lb)) begin
                    fl = 2'b11; e_tag[i] = "R4 nan lane";
                end else begin
                    ra = to_real(la); rb = to_real(lb);
                    fl[1] = ra > rb;
                    fl[0] = ra < -rb;
                    if (ra == 0.0 && rb == 0.0) e_tag[i] = "R6 zero lane";
                    else e_tag[i] = "R2/R3 lane flags";
                end
                any = any | (|fl);
                e_res[32*i +: 32] = {fl, 30'b0};
            end
            e_cond = r ? {2'b00, ~any, 1'b0} : 4'b0000;
        end
    endtask

    function automatic logic [31:0] pick(input int k);
        case (k % 16)
            0: return 32'h3F800000;  1: return 32'hBF800000;
            2: return 32'h40000000;  3: return 32'hC0400000;
            4: return 32'h7F800000;  5: return 32'hFF800000;
            6: return 32'h7FC00000;  7: return 32'hFF800001;
            8: return 32'h00000000;  9: return 32'h80000000;
            10: return 32'h00000001; 11: return 32'h80000002;
            12: return 32'h007FFFFF; 13: return 32'h7F7FFFFF;
            14: return 32'h00800000; default: return 32'hFF7FFFFF;
        endcase
    endfunction

    function automatic logic [127:0] rnd_vec();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            if ($urandom_range(0, 3) == 0) v[32*i +: 32] = pick(int'($urandom_range(0, 15)));
            else v[32*i +: 32] = $urandom;
        end
        return v;
    endfunction

    initial begin
        rst = 1; in_valid = 0; rec_en = 0; opnd_a = '0; opnd_b = '0;
        for (int i = 0; i < 4; i++) e_tag[i] = "R1 reset result";
        repeat (3) @(negedge clk);
        check_outputs();  // R1 reset state
        rst = 0;
        // R2 inside, above; R3 below; R6 zeros
        step({32'h3F800000, 32'h40400000, 32'hC0400000, 32'h80000000},
             {32'h40000000, 32'h40000000, 32'h40000000, 32'h00000000}, 1, 1);
        // R4 NaN in A or B; R6 +0 vs -0
        step({32'h7FC00000, 32'h3F800000, 32'h00000000, 32'h3F800000},
             {32'h40000000, 32'hFFC00001, 32'h80000000, 32'h3F800000}, 1, 1);
        // R3 negative bound gives both flags; infinities; R2 subnormals
        step({32'h00000000, 32'h7F800000, 32'h00000002, 32'h80000002},
             {32'hBF800000, 32'h7F7FFFFF, 32'h00000001, 32'h00000001}, 1, 0);
        // all in range with infinite bound, R7 eq=1
        step({32'h7F7FFFFF, 32'hFF7FFFFF, 32'h00000001, 32'h80000000},
             {32'h7F800000, 32'h7F800000, 32'h00000001, 32'h80000000}, 1, 1);
        // R9 idle with new operands
        step(rnd_vec(), rnd_vec(), 0, 1);
        step(rnd_vec(), rnd_vec(), 0, 0);
        for (int n = 0; n < 3000; n++) begin
            step(rnd_vec(), rnd_vec(), $urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1);
        end
        step('0, '0, 0, 0);
        step('0, '0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule